// File: doc/BRIEF.md
# Fractional PLL Frequency Calculator

This block works out clock frequencies as numbers. It does not produce a clock. A single start pulse captures three 32-bit words: a mode word, a PLL control word and a post-divider word. From the mode word the block picks a reference frequency. It then either passes that reference straight through as the core clock, or runs it through a fractional-N formula. That formula uses a signed numerator, a clamped integer part, a denominator and a pre-divider. The reference is scaled down by 2^10 before the multiply and the quotient is scaled back up afterwards.

Two further clocks follow from the core clock. The high-speed clock is the core clock divided by a small post-divider. The peripheral bus clock is the high-speed clock divided by a second post-divider. All three divisions share one restoring divider that produces one quotient bit per cycle.

The three results stay in registers until the next computation. A combinational query port returns any one of them, a fixed slow-clock rate, or zero.

The control pins are plain. `start` is a one-cycle request, `busy` covers the computation, and `done` pulses once when all three results are new. There is no stream interface and no back-pressure, because results are held and not handed off.

Top module: `fpll_freq_calc`

## Requirements
- R1: The reference frequency is 33554432 (32768 shifted left by 10) when mode bits [2:1] equal 2'b01, and 26000000 for any other value of those bits.
- R2: When mode bit 7 is 1 or mode bit 3 is 0, the core frequency equals the reference and the PLL word has no effect on it.
- R3: Otherwise the core frequency is ((2*(ref>>10)*T) / (D*P)) << 10, truncated to 32 bits, with integer division that truncates. The PLL word fields are: N = bits [9:0] read as signed two's complement; I = bits [13:10], raised to 5 when below 5; D = bits [25:16] + 1; P = bits [29:26] + 1. T is I*D + N. All intermediate values are at least 48 bits wide, so none of them overflows.
- R4: When T is negative in the PLL case, the core frequency is 0.
- R5: The high-speed frequency is the core frequency divided by (1 + post-divider bits [13:11]), truncated.
- R6: The bus frequency is the high-speed frequency divided by (1 + post-divider bits [7:6]), truncated.
- R7: `busy` is 1 from the cycle after an accepted start until the end of the computation. `done` is 1 for exactly one cycle, in the first cycle where all three results hold their new values and `busy` is 0.
- R8: A start that arrives while `busy` is 1 is ignored. It does not change the captured words, and it does not produce an extra `done`.
- R9: `query_hz` returns 0 for select 0, the core frequency for 1, the high-speed frequency for 2, the bus frequency for 3, 32768 for 4, and 0 for 5 to 7.
- R10: After reset, `busy`, `done` and all three frequency outputs are 0.
- R11: While `busy` is 0, the three frequency outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; captures the three words when idle |
| mode_word | input | 32 | Reference select and bypass controls |
| pll_word | input | 32 | Fractional PLL control word |
| postdiv_word | input | 32 | High-speed and bus post-divider fields |
| query_sel | input | 3 | Selects the frequency returned on `query_hz` |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when all results are updated |
| core_hz | output | 32 | Core clock frequency in Hz |
| hs_hz | output | 32 | High-speed clock frequency in Hz |
| bus_hz | output | 32 | Peripheral bus clock frequency in Hz |
| query_hz | output | 32 | Selected frequency in Hz |

## Verification
The assertions take three things for granted. First, `start` is a single-cycle pulse. Second, the captured words change only while the block is idle. Third, every divisor that reaches the divider is nonzero, which follows from the +1 offsets on each field.

The stimulus drives inputs at the falling edge and drops `start` after one cycle. It sweeps the integer field against the pre-divider exhaustively and every post-divider pair exhaustively. It also walks the numerator through its sign boundary and sends a second start while a computation is running. This keeps every divider operand inside the field ranges that the properties assume.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  // Field positions of the PLL control word (decoded by the operand stage).
  typedef struct packed {
    logic [3:0] pre;   // [29:26]
    logic [9:0] den;   // [25:16]
    logic [3:0] whole; // [13:10]
    logic [9:0] num;   // [9:0]
  } pll_fields_t;

  localparam int MODE_SRC_LSB   = 1;
  localparam int MODE_PLLEN_BIT = 3;
  localparam int MODE_BYP_BIT   = 7;
  localparam int PD_HS_LSB      = 11;
  localparam int PD_HS_W        = 3;
  localparam int PD_BUS_LSB     = 6;
  localparam int PD_BUS_W       = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CORE_GO,
    ST_CORE_WAIT,
    ST_HS_GO,
    ST_HS_WAIT,
    ST_BUS_GO,
    ST_BUS_WAIT
  } fpc_state_e;

  typedef enum logic [2:0] {
    QS_NONE = 3'd0,
    QS_CORE = 3'd1,
    QS_HS   = 3'd2,
    QS_BUS  = 3'd3,
    QS_SLOW = 3'd4
  } fpc_query_e;

  function automatic pll_fields_t fpc_unpack(input logic [31:0] w);
    pll_fields_t f;
    f.pre   = w[29:26];
    f.den   = w[25:16];
    f.whole = w[13:10];
    f.num   = w[9:0];
    return f;
  endfunction

endpackage

// File: rtl/fpc_operands.sv
module fpc_operands
  import fpc_pkg::*;
#(
  parameter int FREQ_W      = 32,
  parameter int DIV_W       = 48,
  parameter int SCALE_SH    = 10,
  parameter int WHOLE_MIN   = 5,
  parameter int XTAL_HZ     = 26000000,
  parameter int SLOW_HZ     = 32768,
  parameter int SLOW_MUL_SH = 10
) (
  input  logic [1:0]        src_sel,
  input  logic              pll_en,
  input  logic              byp_req,
  input  pll_fields_t       pll_f,
  output logic [FREQ_W-1:0] ref_hz,
  output logic              bypass,
  output logic              neg_term,
  output logic [DIV_W-1:0]  dividend,
  output logic [DIV_W-1:0]  divisor
);
  localparam int TERM_W = 18;
  localparam int PROD_W = TERM_W - 3;
  localparam logic [FREQ_W-1:0] REF_SLOW = FREQ_W'(SLOW_HZ) << SLOW_MUL_SH;
  localparam logic [FREQ_W-1:0] REF_XTAL = FREQ_W'(XTAL_HZ);

  logic [3:0]               whole_eff;
  logic [10:0]              den_eff;
  logic [4:0]               pre_eff;
  logic [PROD_W-1:0]        whole_prod;
  logic signed [TERM_W-1:0] term;
  logic [FREQ_W-1:0]        ref_scaled;

  always_comb begin
    ref_hz     = (src_sel == 2'b01) ? REF_SLOW : REF_XTAL;
    bypass     = byp_req | ~pll_en;
    whole_eff  = (pll_f.whole < 4'(WHOLE_MIN)) ? 4'(WHOLE_MIN) : pll_f.whole;
    den_eff    = {1'b0, pll_f.den} + 11'd1;
    pre_eff    = {1'b0, pll_f.pre} + 5'd1;
    whole_prod = PROD_W'(whole_eff) * PROD_W'(den_eff);
    term       = $signed({3'b000, whole_prod}) + $signed({{8{pll_f.num[9]}}, pll_f.num});
    neg_term   = term[TERM_W-1];
    ref_scaled = ref_hz >> SCALE_SH;
    if (neg_term) begin
      dividend = '0;
    end else begin
      dividend = (DIV_W'(ref_scaled) * DIV_W'(term[TERM_W-2:0])) << 1;
    end
    divisor = DIV_W'(den_eff) * DIV_W'(pre_eff);
  end

endmodule

// File: rtl/fpc_divider.sv
module fpc_divider #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (go && cnt_q == '0) begin
      quo_q <= dividend;
      rem_q <= '0;
      dvs_q <= divisor;
      cnt_q <= CW'(W);
      done  <= 1'b0;
    end else if (cnt_q != '0) begin
      quo_q <= {quo_q[W-2:0], ~trial[W]};
      rem_q <= trial[W] ? shifted[W-1:0] : trial[W-1:0];
      cnt_q <= cnt_q - 1'b1;
      done  <= (cnt_q == CW'(1));
    end else begin
      done  <= 1'b0;
    end
  end

  assign busy     = (cnt_q != '0);
  assign quotient = quo_q;

  assert_div_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (divisor != '0));
  assert_go_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_q < dvs_q));

endmodule

// File: rtl/fpc_query.sv
module fpc_query
  import fpc_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int SLOW_HZ = 32768
) (
  input  logic [2:0]        sel,
  input  logic [FREQ_W-1:0] core_hz,
  input  logic [FREQ_W-1:0] hs_hz,
  input  logic [FREQ_W-1:0] bus_hz,
  output logic [FREQ_W-1:0] hz
);
  always_comb begin
    case (sel)
      QS_CORE: hz = core_hz;
      QS_HS:   hz = hs_hz;
      QS_BUS:  hz = bus_hz;
      QS_SLOW: hz = FREQ_W'(SLOW_HZ);
      default: hz = '0;
    endcase
  end
endmodule

// File: rtl/fpll_freq_calc.sv
module fpll_freq_calc
  import fpc_pkg::*;
#(
  parameter int FREQ_W      = 32,
  parameter int DIV_W       = 48,
  parameter int SCALE_SH    = 10,
  parameter int WHOLE_MIN   = 5,
  parameter int XTAL_HZ     = 26000000,
  parameter int SLOW_HZ     = 32768,
  parameter int SLOW_MUL_SH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       mode_word,
  input  logic [31:0]       pll_word,
  input  logic [31:0]       postdiv_word,
  input  logic [2:0]        query_sel,
  output logic              busy,
  output logic              done,
  output logic [FREQ_W-1:0] core_hz,
  output logic [FREQ_W-1:0] hs_hz,
  output logic [FREQ_W-1:0] bus_hz,
  output logic [FREQ_W-1:0] query_hz
);
  fpc_state_e state_q;

  // Captured fields
  logic [1:0]          src_q;
  logic                pllen_q;
  logic                byp_q;
  pll_fields_t         pll_q;
  logic [PD_HS_W-1:0]  hsdiv_q;
  logic [PD_BUS_W-1:0] busdiv_q;

  logic [FREQ_W-1:0] ref_hz;
  logic              bypass;
  logic              neg_term;
  logic [DIV_W-1:0]  op_dividend;
  logic [DIV_W-1:0]  op_divisor;

  logic              div_go;
  logic [DIV_W-1:0]  div_a;
  logic [DIV_W-1:0]  div_b;
  logic              div_busy;
  logic              div_done;
  logic [DIV_W-1:0]  div_q;

  fpc_operands #(
    .FREQ_W(FREQ_W), .DIV_W(DIV_W), .SCALE_SH(SCALE_SH), .WHOLE_MIN(WHOLE_MIN),
    .XTAL_HZ(XTAL_HZ), .SLOW_HZ(SLOW_HZ), .SLOW_MUL_SH(SLOW_MUL_SH)
  ) u_ops (
    .src_sel (src_q),
    .pll_en  (pllen_q),
    .byp_req (byp_q),
    .pll_f   (pll_q),
    .ref_hz  (ref_hz),
    .bypass  (bypass),
    .neg_term(neg_term),
    .dividend(op_dividend),
    .divisor (op_divisor)
  );

  always_comb begin
    div_go = 1'b0;
    div_a  = '0;
    div_b  = DIV_W'(1);
    case (state_q)
      ST_CORE_GO: begin
        div_go = ~bypass & ~neg_term;
        div_a  = op_dividend;
        div_b  = op_divisor;
      end
      ST_HS_GO: begin
        div_go = 1'b1;
        div_a  = DIV_W'(core_hz);
        div_b  = DIV_W'(hsdiv_q) + DIV_W'(1);
      end
      ST_BUS_GO: begin
        div_go = 1'b1;
        div_a  = DIV_W'(hs_hz);
        div_b  = DIV_W'(busdiv_q) + DIV_W'(1);
      end
      default: ;
    endcase
  end

  fpc_divider #(.W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (div_go),
    .dividend(div_a),
    .divisor (div_b),
    .busy    (div_busy),
    .done    (div_done),
    .quotient(div_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      src_q    <= '0;
      pllen_q  <= 1'b0;
      byp_q    <= 1'b0;
      pll_q    <= '0;
      hsdiv_q  <= '0;
      busdiv_q <= '0;
      core_hz  <= '0;
      hs_hz    <= '0;
      bus_hz   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          src_q    <= mode_word[MODE_SRC_LSB +: 2];
          pllen_q  <= mode_word[MODE_PLLEN_BIT];
          byp_q    <= mode_word[MODE_BYP_BIT];
          pll_q    <= fpc_unpack(pll_word);
          hsdiv_q  <= postdiv_word[PD_HS_LSB +: PD_HS_W];
          busdiv_q <= postdiv_word[PD_BUS_LSB +: PD_BUS_W];
          state_q  <= ST_CORE_GO;
        end
        ST_CORE_GO: begin
          if (bypass) begin
            core_hz <= ref_hz;
            state_q <= ST_HS_GO;
          end else if (neg_term) begin
            core_hz <= '0;
            state_q <= ST_HS_GO;
          end else begin
            state_q <= ST_CORE_WAIT;
          end
        end
        ST_CORE_WAIT: if (div_done) begin
          core_hz <= FREQ_W'(div_q << SCALE_SH);
          state_q <= ST_HS_GO;
        end
        ST_HS_GO: state_q <= ST_HS_WAIT;
        ST_HS_WAIT: if (div_done) begin
          hs_hz   <= FREQ_W'(div_q);
          state_q <= ST_BUS_GO;
        end
        ST_BUS_GO: state_q <= ST_BUS_WAIT;
        ST_BUS_WAIT: if (div_done) begin
          bus_hz  <= FREQ_W'(div_q);
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  fpc_query #(.FREQ_W(FREQ_W), .SLOW_HZ(SLOW_HZ)) u_query (
    .sel    (query_sel),
    .core_hz(core_hz),
    .hs_hz  (hs_hz),
    .bus_hz (bus_hz),
    .hz     (query_hz)
  );

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_div_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !div_busy);
  assert_chain_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((bus_hz <= hs_hz) && (hs_hz <= core_hz)));
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pll_q) && $stable(src_q) && $stable(hsdiv_q) && $stable(busdiv_q)));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(core_hz) && $stable(hs_hz) && $stable(bus_hz)));

endmodule

// File: tb/fpll_freq_calc_bench.sv
module fpll_freq_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] mode_word = '0;
  logic [31:0] pll_word = '0;
  logic [31:0] postdiv_word = '0;
  logic [2:0]  query_sel = '0;
  logic        busy, done;
  logic [31:0] core_hz, hs_hz, bus_hz, query_hz;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk; // 50 MHz

  fpll_freq_calc u_fpll_freq_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
    .pll_word(pll_word), .postdiv_word(postdiv_word), .query_sel(query_sel),
    .busy(busy), .done(done), .core_hz(core_hz), .hs_hz(hs_hz),
    .bus_hz(bus_hz), .query_hz(query_hz)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] m, input logic [31:0] p,
                                input logic [31:0] d, output logic [31:0] c,
                                output logic [31:0] h, output logic [31:0] b,
                                output bit negative);
    longint rf, n, wi, dn, pr, t, q;
    rf = (m[2:1] == 2'b01) ? 64'd33554432 : 64'd26000000;
    negative = 0;
    if (m[7] || !m[3]) begin
      c = 32'(rf);
    end else begin
      n  = p[9] ? longint'(p[9:0]) - 1024 : longint'(p[9:0]);
      wi = (p[13:10] < 5) ? 5 : longint'(p[13:10]);
      dn = longint'(p[25:16]) + 1;
      pr = longint'(p[29:26]) + 1;
      t  = wi * dn + n;
      if (t < 0) begin
        negative = 1;
        c = 0;
      end else begin
        q = (2 * (rf >> 10) * t) / (dn * pr);
        c = 32'(q << 10);
      end
    end
    h = c / (32'd1 + 32'(d[13:11]));
    b = h / (32'd1 + 32'(d[7:6]));
  endfunction

  // Starts one computation and waits for done; returns 1 if done was seen.
  task automatic launch_and_wait(input logic [31:0] m, input logic [31:0] p,
                                 input logic [31:0] d, output bit seen);
    @(negedge clk);
    mode_word = m; pll_word = p; postdiv_word = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int k = 0; k < 400 && !seen; k++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
  endtask

  task automatic run(input logic [31:0] m, input logic [31:0] p,
                     input logic [31:0] d, input string ctag);
    logic [31:0] ec, eh, eb;
    bit neg, seen;
    model(m, p, d, ec, eh, eb, neg);
    launch_and_wait(m, p, d, seen);
    chk("R7 done seen", 32'(seen), 32'd1);
    chk(neg ? "R4 core" : ctag, core_hz, ec);
    chk("R5 hs", hs_hz, eh);
    chk("R6 bus", bus_hz, eb);
    @(negedge clk);
    chk("R7 done single", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] ec, eh, eb;
    bit neg, seen;
    int dones;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 core", core_hz, 0);
    chk("R10 hs", hs_hz, 0);
    chk("R10 bus", bus_hz, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 query after reset
    for (int s = 0; s < 8; s++) begin
      query_sel = 3'(s);
      #1 chk("R9 query reset", query_hz, (s == 4) ? 32'd32768 : 32'd0);
    end

    // R1/R2 mode sweep over bits 1,2,3,7
    for (int i = 0; i < 16; i++) begin
      logic [31:0] m;
      m = 32'h0400_0000;
      m[1] = i[0]; m[2] = i[1]; m[3] = i[2]; m[7] = i[3];
      run(m, 32'h0409_1803, 32'h0000_0840, (m[7] || !m[3]) ? "R2 bypass core" : "R1 ref via pll");
    end
    // R2: PLL word has no effect in bypass
    run(32'h0000_0080, 32'h3FFF_3FFF, 32'h0, "R2 bypass ignores pll");
    run(32'h0000_0002, 32'h2000_0000, 32'h0, "R1 slow ref bypass");

    // R3 integer field against pre-divider, exhaustive
    for (int wi = 0; wi < 16; wi++)
      for (int pr = 0; pr < 16; pr++)
        run((pr % 2) ? 32'h0000_000A : 32'h0000_0008,
            (32'(pr) << 26) | (32'd9 << 16) | (32'(wi) << 10) | 32'd3,
            32'h0, "R3 core");

    // R3/R4 numerator sign and denominator corners
    begin
      logic [9:0] nums [6] = '{10'd0, 10'd1, 10'd511, 10'd512, 10'd1023, 10'd600};
      logic [9:0] dens [4] = '{10'd0, 10'd1, 10'd4, 10'd1023};
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 2; c++)
            run(32'h0000_0008,
                32'h0400_0000 | (32'(dens[b]) << 16) | (c ? 32'hF << 10 : 32'h0) | 32'(nums[a]),
                32'h0000_0800, "R3 core numerator");
    end

    // R5/R6 post-divider sweep, exhaustive
    for (int hd = 0; hd < 8; hd++)
      for (int bd = 0; bd < 4; bd++)
        run(32'h0000_0008, 32'h0004_1C05, (32'(hd) << 11) | (32'(bd) << 6) | 32'hFFE0_0000,
            "R3 core postdiv");

    // R9 query returns held results
    model(32'h0000_0008, 32'h0004_1C05, 32'h0000_1840, ec, eh, eb, neg);
    run(32'h0000_0008, 32'h0004_1C05, 32'h0000_1840, "R3 core query");
    query_sel = 3'd1; #1 chk("R9 query core", query_hz, ec);
    query_sel = 3'd2; #1 chk("R9 query hs", query_hz, eh);
    query_sel = 3'd3; #1 chk("R9 query bus", query_hz, eb);
    query_sel = 3'd4; #1 chk("R9 query slow", query_hz, 32'd32768);
    query_sel = 3'd7; #1 chk("R9 query none", query_hz, 32'd0);

    // R7/R8: second start while busy is ignored
    model(32'h0000_0008, 32'h0412_2C10, 32'h0000_0840, ec, eh, eb, neg);
    @(negedge clk);
    mode_word = 32'h0000_0008; pll_word = 32'h0412_2C10; postdiv_word = 32'h0000_0840;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", 32'(busy), 32'd1);
    repeat (5) @(negedge clk);
    mode_word = 32'h0000_0080; pll_word = 32'h0; postdiv_word = 32'h0000_38C0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    for (int k = 0; k < 600; k++) begin
      if (done) begin
        dones++;
        if (dones == 1) begin
          chk("R8 core first words", core_hz, ec);
          chk("R8 hs first words", hs_hz, eh);
          chk("R8 bus first words", bus_hz, eb);
          chk("R7 idle at done", 32'(busy), 32'd0);
        end
      end
      @(negedge clk);
    end
    chk("R8 single done", 32'(dones), 32'd1);

    // R11 idle hold with inputs toggling and no start
    mode_word = 32'hFFFF_FFFF; pll_word = 32'h1234_5678; postdiv_word = 32'hFFFF_FFFF;
    repeat (20) @(negedge clk);
    chk("R11 core hold", core_hz, ec);
    chk("R11 hs hold", hs_hz, eh);
    chk("R11 bus hold", bus_hz, eb);
    chk("R11 still idle", 32'(busy), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule